// File: doc/BRIEF.md
# Flow-Control Update Scheduler

This block sits on the receive side of a serial packet link. It decides when the transmit path should send a flow-control update that tells the far-end sender how many receive-buffer credits have been freed. It also decides whether that update should be sent at normal or high priority. It handles one credit type per instance. It watches four running values:

- the credits-allocated counter;
- the credits-received counter;
- the total buffer capacity;
- the largest payload a packet may carry.

It also watches a free-running one-microsecond tick.

Three independent conditions can cause a request:

- **Starvation:** the far-end sender holds too few credits for a full payload.
- **Resend:** the periodic resend interval has elapsed.
- **Threshold:** a large share of the buffer has been freed since the last advertisement.

Only the threshold condition makes the request high priority. When the transmit path grants the request, the block does three things. It records the advertised value, restarts the resend interval and withdraws the request.

A four-state machine controls the block:

- **IDLE:** the link is down. The recorded value follows the allocated counter.
- **INIT:** the first update after the link comes up is pending.
- **ARMED:** no request is pending, and the block waits for a condition.
- **PEND:** a request is pending.

The transitions are:

- IDLE→INIT when the link comes up.
- INIT→ARMED on a grant.
- ARMED→PEND when any condition is active.
- PEND→ARMED on a grant.
- Any state other than IDLE→IDLE when the link drops.

Top module: `fcu_sched`

## Requirements
- R1: While reset is asserted, and while the link stays down after reset, `upd_req` and `upd_hi_pri` are 0.
- R2: One clock after `link_up` is first seen high, `upd_req` is 1. It stays 1 until a grant is seen.
- R3: Starvation trigger. A request is raised when two conditions hold together. The first is that the held credits, (last advertised − `cred_rcvd`) mod 2^CW, are less than `max_payload`. The second is that at least one credit has been freed since the last advertisement. Starvation with nothing freed raises no request. A raised request stays high until it is granted.
- R4: Resend trigger. A request is raised once RESEND_US ticks of `us_tick` have been counted since the last grant. The tick that reaches the limit is seen first, then the request appears one clock later. The priority is normal unless the threshold trigger also holds.
- R5: Threshold trigger. Let freed = (`cred_alloc` − last advertised) mod 2^CW. When freed is nonzero and 4·freed ≥ `buf_total`, a request is raised and `upd_hi_pri` is 1. `upd_hi_pri` is never 1 without `upd_req`. When several triggers are active, there is one request, and its priority is high if the threshold holds.
- R6: On a grant while requesting, three things happen. The current `cred_alloc` becomes the last advertised value. The resend count restarts from zero. `upd_req` is 0 on the next clock.
- R7: All credit differences are taken modulo 2^CW, so counters that wrap past zero give correct triggers.
- R8: `upd_credit` carries the current `cred_alloc` value to advertise.
- R9: A grant while no request is pending has no effect. It does not restart the resend count and does not change the last advertised value.
- R10: When the link drops, `upd_req` is 0 on the next clock. When the link comes back up, a new initial update is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Link is trained and able to carry updates |
| cred_alloc | input | CW | Running count of credits allocated (freed) by the receiver |
| cred_rcvd | input | CW | Running count of credits consumed by received packets |
| buf_total | input | CW | Total receive-buffer capacity in credits |
| max_payload | input | CW | Credits needed by one maximum-size payload |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| tx_grant | input | 1 | Transmit path accepts the pending update |
| upd_req | output | 1 | Update request |
| upd_hi_pri | output | 1 | Request is high priority |
| upd_credit | output | CW | Credit value to advertise |

## Verification
The threshold condition is swept one credit at a time across its 25% boundary. The exact step where the request and the high priority both appear separates a correct comparison from an off-by-one or a wrong scale. The held-credit value is swept across the maximum payload, with a single freed credit. This separates the strict less-than test from less-or-equal, and it shows that starvation never sets the high priority. Tick sequences with a grant inserted while no request is pending show two things: the resend limit is exact, and only real grants restart the count. Counter values that straddle the 2^CW wrap in both the freed and the held difference reveal any arithmetic that is not modular.

// File: rtl/fcu_pkg.sv
package fcu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INIT  = 2'd1,
        ST_ARMED = 2'd2,
        ST_PEND  = 2'd3
    } fcu_state_e;

    typedef struct packed {
        logic starve;
        logic resend;
        logic thresh;
    } fcu_trig_s;

endpackage

// File: rtl/fcu_trig.sv
module fcu_trig
    import fcu_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic [CW-1:0] cred_alloc,
    input  logic [CW-1:0] last_sent,
    input  logic [CW-1:0] cred_rcvd,
    input  logic [CW-1:0] buf_total,
    input  logic [CW-1:0] max_payload,
    input  logic          resend_due,
    output fcu_trig_s     trig
);
    localparam int EW = CW + 2;

    logic [CW-1:0] freed;
    logic [CW-1:0] held;
    logic [EW-1:0] freed_x4;
    logic [EW-1:0] total_ext;
    logic          any_freed;

    // modular differences (R7)
    always_comb begin
        freed     = cred_alloc - last_sent;
        held      = last_sent - cred_rcvd;
        freed_x4  = {freed, 2'b00};
        total_ext = {2'b00, buf_total};
        any_freed = (freed != '0);
    end

    always_comb begin
        trig.thresh = any_freed && (freed_x4 >= total_ext);   // R5
        trig.starve = any_freed && (held < max_payload);      // R3
        trig.resend = resend_due;                             // R4
    end

endmodule

// File: rtl/fcu_timer.sv
module fcu_timer #(
    parameter int LIMIT = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic tick,
    output logic due
);
    localparam int TW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LIM = TW'(LIMIT);

    logic [TW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (!run || restart) begin
            count_q <= '0;
        end else if (tick && (count_q != LIM)) begin
            count_q <= count_q + 1'b1;
        end
    end

    always_comb begin
        due = run && (count_q == LIM);
    end

endmodule

// File: rtl/fcu_sched.sv
module fcu_sched
    import fcu_pkg::*;
#(
    parameter int CW        = 8,
    parameter int RESEND_US = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          link_up,
    input  logic [CW-1:0] cred_alloc,
    input  logic [CW-1:0] cred_rcvd,
    input  logic [CW-1:0] buf_total,
    input  logic [CW-1:0] max_payload,
    input  logic          us_tick,
    input  logic          tx_grant,
    output logic          upd_req,
    output logic          upd_hi_pri,
    output logic [CW-1:0] upd_credit
);
    fcu_state_e    state_q, state_d;
    fcu_trig_s     trig;
    logic [CW-1:0] last_sent_q;
    logic          resend_due;
    logic          requesting;
    logic          grant_take;
    logic          any_trig;
    logic          timer_run;

    always_comb begin
        requesting = (state_q == ST_INIT) || (state_q == ST_PEND);
        grant_take = requesting && tx_grant && link_up;       // R6, R9
        any_trig   = trig.starve || trig.resend || trig.thresh;
        timer_run  = (state_q == ST_ARMED) || (state_q == ST_PEND);
    end

    fcu_timer #(
        .LIMIT (RESEND_US)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timer_run),
        .restart (grant_take),
        .tick    (us_tick),
        .due     (resend_due)
    );

    fcu_trig #(
        .CW (CW)
    ) u_trig (
        .cred_alloc  (cred_alloc),
        .last_sent   (last_sent_q),
        .cred_rcvd   (cred_rcvd),
        .buf_total   (buf_total),
        .max_payload (max_payload),
        .resend_due  (resend_due),
        .trig        (trig)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (link_up) state_d = ST_INIT;
            ST_INIT:  if (!link_up) state_d = ST_IDLE;
                      else if (tx_grant) state_d = ST_ARMED;
            ST_ARMED: if (!link_up) state_d = ST_IDLE;
                      else if (any_trig) state_d = ST_PEND;
            ST_PEND:  if (!link_up) state_d = ST_IDLE;
                      else if (tx_grant) state_d = ST_ARMED;
            default:  state_d = ST_IDLE;
        endcase
    end

    // last advertised value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_sent_q <= '0;
        end else if (state_q == ST_IDLE || grant_take) begin
            last_sent_q <= cred_alloc;
        end
    end

    // outputs
    always_comb begin
        upd_req    = requesting;
        upd_hi_pri = requesting && trig.thresh;
        upd_credit = cred_alloc;
    end

endmodule

// File: rtl/fcu_sched_chk.sv
module fcu_sched_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          link_up,
    input logic          tx_grant,
    input logic          upd_req,
    input logic          upd_hi_pri,
    input logic [CW-1:0] upd_credit
);
    AST_REQ_ON_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up) |=> upd_req);                                 // R2
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_req && !tx_grant && link_up) |=> upd_req);              // R3
    AST_GRANT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_req && tx_grant) |=> !upd_req);                         // R6
    AST_HI_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        upd_hi_pri |-> upd_req);                                     // R5
    AST_LINK_DOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> !upd_req);                                      // R10
    AST_CREDIT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        upd_req |-> !$isunknown(upd_credit));                        // R8
endmodule

bind fcu_sched fcu_sched_chk #(.CW(CW)) u_fcu_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_up    (link_up),
    .tx_grant   (tx_grant),
    .upd_req    (upd_req),
    .upd_hi_pri (upd_hi_pri),
    .upd_credit (upd_credit)
);

// File: tb/test_fcu_sched.sv
module test_fcu_sched;
    localparam int CLK_P = 10;
    localparam int CW    = 8;
    localparam int LIM   = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          link_up;
    logic [CW-1:0] cred_alloc, cred_rcvd, buf_total, max_payload;
    logic          us_tick, tx_grant;
    logic          upd_req, upd_hi_pri;
    logic [CW-1:0] upd_credit;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    fcu_sched #(.CW(CW), .RESEND_US(LIM)) i_fcu_sched (
        .clk(clk), .rst_n(rst_n), .link_up(link_up),
        .cred_alloc(cred_alloc), .cred_rcvd(cred_rcvd),
        .buf_total(buf_total), .max_payload(max_payload),
        .us_tick(us_tick), .tx_grant(tx_grant),
        .upd_req(upd_req), .upd_hi_pri(upd_hi_pri), .upd_credit(upd_credit)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic grant();
        tx_grant = 1'b1;
        step(1);
        tx_grant = 1'b0;
    endtask

    task automatic ticks(input int k);
        for (int i = 0; i < k; i++) begin
            us_tick = 1'b1;
            step(1);
            us_tick = 1'b0;
            step(1);
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; link_up = 1'b0; cred_alloc = '0; cred_rcvd = '0;
        buf_total = 8'd40; max_payload = 8'd16; us_tick = 1'b0; tx_grant = 1'b0;
        step(3);
        chk("R1 req in reset", upd_req, 0);
        chk("R1 hi in reset", upd_hi_pri, 0);
        rst_n = 1'b1;
        step(3);
        chk("R1 req link down", upd_req, 0);

        // initial update
        cred_alloc = 8'd100; link_up = 1'b1;
        step(1);
        chk("R2 initial req", upd_req, 1);
        chk("R8 credit", upd_credit, 100);
        step(3);
        chk("R2 req held", upd_req, 1);
        grant();
        chk("R6 drop after grant", upd_req, 0);

        // resend timer and ignored grant
        ticks(3);
        chk("R4 no req at 3 ticks", upd_req, 0);
        grant();
        chk("R9 stray grant no req", upd_req, 0);
        ticks(1);
        chk("R4 no req at 4 ticks", upd_req, 0);
        ticks(1);
        chk("R9 timer not restarted", upd_req, 1);
        chk("R4 resend normal pri", upd_hi_pri, 0);
        grant();
        chk("R6 drop", upd_req, 0);
        ticks(LIM - 1);
        chk("R6 timer restarted", upd_req, 0);
        ticks(1);
        chk("R4 resend again", upd_req, 1);
        grant();

        // threshold sweep, last=100, total=40 -> boundary 10
        for (int f = 0; f <= 20; f++) begin
            cred_alloc = 8'(100 + f);
            step(1);
            chk($sformatf("R5 req f=%0d", f), upd_req, (f >= 10) ? 1 : 0);
            chk($sformatf("R5 hi f=%0d", f), upd_hi_pri, (f >= 10) ? 1 : 0);
        end
        grant();
        chk("R6 drop after thresh", upd_req, 0);

        // starvation sweep, last=120, one freed credit
        cred_alloc = 8'd121;
        for (int r = 100; r <= 110; r++) begin
            cred_rcvd = 8'(r);
            step(1);
            chk($sformatf("R3 req r=%0d", r), upd_req, (r >= 105) ? 1 : 0);
            chk($sformatf("R3 hi r=%0d", r), upd_hi_pri, 0);
        end
        grant();
        step(3);
        chk("R3 starve without freed", upd_req, 0);

        // wraparound
        cred_rcvd = 8'd200;
        cred_alloc = 8'd250;
        step(1);
        chk("R5 big freed hi", upd_hi_pri, 1);
        grant();
        cred_rcvd = 8'd245;
        step(2);
        chk("R7 no req held 5 freed 0", upd_req, 0);
        cred_alloc = 8'd4;
        step(1);
        chk("R7 freed wraps req", upd_req, 1);
        chk("R7 freed wraps hi", upd_hi_pri, 1);
        grant();
        cred_rcvd = 8'd250;
        step(2);
        chk("R7 held wraps no freed", upd_req, 0);
        cred_alloc = 8'd5;
        step(1);
        chk("R7 held wraps starve", upd_req, 1);
        chk("R7 starve normal pri", upd_hi_pri, 0);
        cred_alloc = 8'd14;
        step(1);
        chk("R5 escalate pending", upd_hi_pri, 1);

        // link drop
        link_up = 1'b0;
        step(1);
        chk("R10 req drops", upd_req, 0);
        chk("R10 hi drops", upd_hi_pri, 0);
        step(2);
        chk("R10 stays quiet", upd_req, 0);
        cred_alloc = 8'd20; link_up = 1'b1;
        step(1);
        chk("R10 initial again", upd_req, 1);
        chk("R8 credit again", upd_credit, 20);
        grant();
        cred_alloc = 8'd29;
        step(1);
        chk("R6 latch below thresh", upd_req, 0);
        cred_alloc = 8'd30;
        step(1);
        chk("R6 latch at thresh", upd_hi_pri, 1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule